// File: doc/BRIEF.md
# Strobed I/O Write Capture Buffer

This block records every byte that a target processor places on its data bus while it pulses an I/O-enable strobe. The strobe arrives without any relation to the local clock. It passes through a short synchronizer chain, and each active (falling) edge found at the end of that chain writes the current data bus value into a 256-entry circular store. No per-byte software action is needed: capture runs freely for as long as the block is out of reset.

The writer does not keep a write pointer. It keeps a transfer counter that starts at the buffer depth, counts down by one on every capture and goes back to the depth after the last entry. The consumer side keeps a second counter of the same kind. A byte is pending whenever the two counters differ. A consumer issues a single-cycle pop request. One cycle later the block answers with one of two things. If a byte was pending, it returns that byte, taken from entry (depth minus reader count), and the reader counter steps down. If nothing was pending, it returns an empty indication and no state changes. The block detects no overflow. After exactly one buffer's worth of unread captures the counters coincide, and the pending bytes are no longer visible.

Top module: `strobe_capture_buf`

## Requirements
- R1: After reset, avail_o, rd_valid_o and rd_empty_o are all 0.
- R2: Each high-to-low transition of strobe_n_i stores exactly one byte, however long the strobe stays low. A low-to-high transition stores nothing.
- R3: If strobe_n_i falls just after rising clock edge k (with data_i already stable), avail_o is still 0 after edge k+2 and is 1 after edge k+3.
- R4: A pop_i pulse while avail_o is 1 gives rd_valid_o = 1 for exactly the next cycle, with rd_data_o equal to the oldest unread captured byte. Bytes come out in capture order.
- R5: A pop_i pulse while avail_o is 0 gives rd_empty_o = 1 for exactly the next cycle, with rd_valid_o = 0. It changes neither counter.
- R6: Both counters run from 256 down to 1 and reload to 256. Entry index = 256 − count. Capture order is kept across any number of wraps.
- R7: When 256 captures occur with no pop in between, the counters become equal and avail_o is 0. The next capture after that is readable again.
- R8: data_i is sampled only in the cycle of the synchronized falling edge. Changes to data_i while strobe_n_i stays low do not affect the stored byte.
- R9: rd_valid_o and rd_empty_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_n_i | input | 1 | Asynchronous I/O-enable strobe from the target, active low |
| data_i | input | 8 | Target data bus |
| pop_i | input | 1 | Consumer read request, one cycle per byte |
| avail_o | output | 1 | At least one captured byte is pending |
| rd_valid_o | output | 1 | Response to the previous pop carries a byte |
| rd_empty_o | output | 1 | Response to the previous pop found nothing pending |
| rd_data_o | output | 8 | Byte returned with rd_valid_o |

## Verification
The hardest state to reach is counter coincidence after a full buffer of unread captures. In that state avail_o drops even though 256 bytes were written. The stimulus reaches it by issuing exactly 256 strobes back to back with no pop, starting from counter values already shifted by earlier traffic. It then checks that avail_o is low, that a pop returns the empty indication, and that a single further strobe is read back correctly. Long strobe pulses with the data bus changed partway through the low phase show that only the edge cycle samples the bus.

// File: rtl/scb_pkg.sv
package scb_pkg;

  // Kind of answer the consumer port gives one cycle after a pop.
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_BYTE  = 2'd1,
    RSP_EMPTY = 2'd2
  } rsp_kind_e;

endpackage

// File: rtl/scb_edge_sync.sv
// Brings the asynchronous strobe into the clock domain and flags its active edge.
module scb_edge_sync #(
  parameter int SYNC_STAGES = 2,
  parameter bit ACTIVE_LOW  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic edge_o
);

  localparam logic IDLE_LVL = ACTIVE_LOW;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   synced;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {SYNC_STAGES{IDLE_LVL}};
      prev_q <= IDLE_LVL;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign synced = sync_q[SYNC_STAGES-1];

  generate
    if (ACTIVE_LOW) begin : g_fall
      assign edge_o = prev_q & ~synced;
    end else begin : g_rise
      assign edge_o = ~prev_q & synced;
    end
  endgenerate

  // R2: one level change yields a single-cycle capture pulse
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);

endmodule

// File: rtl/scb_ram.sv
// Simple dual-port store, one write port and one registered read port.
module scb_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/scb_writer.sv
// Capture side: down-counting transfer counter that selects the entry to fill.
module scb_writer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [CNT_W-1:0]  cnt_o
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= FULL;
    end else if (cap_i) begin
      cnt_q <= (cnt_q == ONE) ? FULL : cnt_q - ONE;
    end
  end

  // The bus is taken in the same cycle the synchronized edge is seen.
  assign we_o    = cap_i;
  assign waddr_o = AW'(FULL - cnt_q);
  assign wdata_o = data_i;
  assign cnt_o   = cnt_q;

  // R6: counter stays in 1..DEPTH
  p_wr_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= ONE) && (cnt_q <= FULL));

  // R6: each capture moves the counter, no capture leaves it alone
  p_wr_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    cap_i |=> (cnt_q != $past(cnt_q)));

  p_wr_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cap_i |=> $stable(cnt_q));

endmodule

// File: rtl/scb_reader.sv
// Consumer side: own copy of the counter, pending test and registered answer.
module scb_reader #(
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  output logic             re_o,
  output logic [AW-1:0]    raddr_o,
  output logic             avail_o,
  output logic             valid_o,
  output logic             empty_o
);

  import scb_pkg::*;

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  rsp_kind_e        rsp_q;
  logic             pending;

  assign pending = (cnt_q != wr_cnt_i);
  assign re_o    = pop_i & pending;
  assign raddr_o = AW'(FULL - cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= FULL;
      rsp_q <= RSP_NONE;
    end else begin
      if (re_o) begin
        cnt_q <= (cnt_q == ONE) ? FULL : cnt_q - ONE;
      end
      if (!pop_i)       rsp_q <= RSP_NONE;
      else if (pending) rsp_q <= RSP_BYTE;
      else              rsp_q <= RSP_EMPTY;
    end
  end

  assign avail_o = pending;
  assign valid_o = (rsp_q == RSP_BYTE);
  assign empty_o = (rsp_q == RSP_EMPTY);

  // R4: a pop with data pending yields a byte next cycle
  p_pop_byte_r4: assert property (@(posedge clk) disable iff (rst)
    (pop_i && avail_o) |=> (valid_o && !empty_o));

  // R5: a pop with nothing pending yields the empty answer and keeps the count
  p_pop_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !avail_o) |=> (empty_o && $stable(cnt_q)));

  // R9: the two answers exclude each other
  p_rsp_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && empty_o));

  // R4: an answer only follows a request
  p_rsp_needs_pop_r4: assert property (@(posedge clk) disable iff (rst)
    !pop_i |=> !(valid_o || empty_o));

endmodule

// File: rtl/strobe_capture_buf.sv
module strobe_capture_buf #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2,
  parameter bit ACTIVE_LOW  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_n_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic              avail_o,
  output logic              rd_valid_o,
  output logic              rd_empty_o,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic              cap;
  logic              we;
  logic [AW-1:0]     waddr;
  logic [DATA_W-1:0] wdata;
  logic [CNT_W-1:0]  wr_cnt;
  logic              re;
  logic [AW-1:0]     raddr;

  scb_edge_sync #(
    .SYNC_STAGES(SYNC_STAGES),
    .ACTIVE_LOW (ACTIVE_LOW)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .strobe_i(strobe_n_i),
    .edge_o  (cap)
  );

  scb_writer #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_wr (
    .clk    (clk),
    .rst    (rst),
    .cap_i  (cap),
    .data_i (data_i),
    .we_o   (we),
    .waddr_o(waddr),
    .wdata_o(wdata),
    .cnt_o  (wr_cnt)
  );

  scb_ram #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_ram (
    .clk    (clk),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .re_i   (re),
    .raddr_i(raddr),
    .rdata_o(rd_data_o)
  );

  scb_reader #(
    .DEPTH(DEPTH)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .pop_i   (pop_i),
    .wr_cnt_i(wr_cnt),
    .re_o    (re),
    .raddr_o (raddr),
    .avail_o (avail_o),
    .valid_o (rd_valid_o),
    .empty_o (rd_empty_o)
  );

  // R7: a capture always makes data pending unless it closes a full lap
  p_cap_sets_avail_r7: assert property (@(posedge clk) disable iff (rst)
    (cap && !avail_o && !pop_i) |=> avail_o);

endmodule

// File: tb/sim_strobe_capture_buf.sv
module sim_strobe_capture_buf;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe_n = 1'b1;
  logic [7:0] data = 8'h00;
  logic       pop = 1'b0;
  logic       avail, rvalid, rempty;
  logic [7:0] rdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [7:0] sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_capture_buf u0 (
    .clk       (clk),
    .rst       (rst),
    .strobe_n_i(strobe_n),
    .data_i    (data),
    .pop_i     (pop),
    .avail_o   (avail),
    .rd_valid_o(rvalid),
    .rd_empty_o(rempty),
    .rd_data_o (rdata)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: one strobe pulse, expected byte goes to the scoreboard.
  task automatic strobe_byte(input logic [7:0] b, input int low_cycles);
    @(negedge clk);
    data = b;
    strobe_n = 1'b0;
    sb_q.push_back(b);
    repeat (low_cycles) @(negedge clk);
    strobe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pop_one();
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    check(rvalid ^ rempty, "R9 one answer per pop", {rvalid, rempty}, 2'b10);
  endtask

  // Monitor: compares every answer against the scoreboard.
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R4 byte with empty scoreboard", rdata, 0);
      end else begin
        logic [7:0] e;
        e = sb_q.pop_front();
        check(rdata == e, "R4 data order", rdata, e);
      end
    end
    if (!rst && rempty) begin
      check(sb_q.size() == 0, "R5 empty answer", 1, sb_q.size() == 0);
    end
  end

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!avail && !rvalid && !rempty, "R1 reset outputs", {avail, rvalid, rempty}, 0);

    // R5: pop on empty
    pop_one();
    check(avail == 1'b0, "R5 avail after empty pop", avail, 0);

    // R3: latency of the synchronizer and write
    @(negedge clk);
    data = 8'hA5;
    strobe_n = 1'b0;
    sb_q.push_back(8'hA5);
    @(negedge clk);
    @(negedge clk);
    check(avail == 1'b0, "R3 not yet pending", avail, 0);
    @(negedge clk);
    check(avail == 1'b1, "R3 pending", avail, 1);
    @(negedge clk);
    strobe_n = 1'b1;
    repeat (4) @(negedge clk);
    pop_one();
    // R2: rising edge stored nothing
    check(avail == 1'b0, "R2 no capture on rising edge", avail, 0);
    pop_one();

    // R8: data changes during a long low phase
    @(negedge clk);
    data = 8'h3C;
    strobe_n = 1'b0;
    sb_q.push_back(8'h3C);
    repeat (4) @(negedge clk);
    data = 8'hFF;
    repeat (6) @(negedge clk);
    data = 8'h11;
    strobe_n = 1'b1;
    repeat (3) @(negedge clk);
    pop_one();  // R8 checked by monitor: 3C expected
    check(avail == 1'b0, "R2 one byte per long pulse", avail, 0);

    // R4: burst of bytes then burst of pops
    for (int i = 0; i < 20; i++) strobe_byte(8'(i * 13 + 1), 4);
    for (int i = 0; i < 20; i++) pop_one();
    pop_one();

    // R6: interleaved traffic across more than one wrap
    for (int i = 0; i < 300; i++) begin
      strobe_byte(8'(i * 7 + 3), 4);
      if (i % 3 != 0) pop_one();
    end
    while (sb_q.size() != 0) pop_one();
    check(avail == 1'b0, "R6 drained after wrap", avail, 0);

    // R7: a full lap of unread captures makes the counters coincide
    for (int i = 0; i < 256; i++) strobe_byte(8'(255 - i), 4);
    check(avail == 1'b0, "R7 avail low after full lap", avail, 0);
    sb_q.delete();
    pop_one();
    strobe_byte(8'h5A, 4);
    check(avail == 1'b1, "R7 next capture pending", avail, 1);
    pop_one();
    pop_one();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule